// File: doc/BRIEF.md
# Strided Vector Memory Access Sequencer

This block turns one vector load or store into a stream of per-element memory requests. The issuing unit supplies a base byte address, a stride counted in 8-byte elements (two's complement, so it may be zero or negative) taken from a scalar register at issue time, and an element count. The block walks the addresses with a running adder, sends at most one request per cycle to a memory split into independent banks, and holds a request back while its target bank is still occupied by an earlier one.

For a load, the memory answers each request after a fixed latency and in issue order. The block writes the k-th answer into vector register slot k, so the register is filled densely whatever the spacing in memory. A one-cycle flag marks the arrival of slot 0 so a consumer can start early, and a one-cycle completion pulse follows the last slot. For a store, the same address sequence is used and slot i is read out of the register as request i leaves.

Top module: `strided_vec_agu`

## Requirements
- R1: While reset is held and after its release with no command, `busy`, `done`, `first_valid`, `mem_req_valid` and `vr_we` are all 0.
- R2: Request i (counting from 0) carries address `base_addr + i*stride*8` modulo 2^ADDR_W, where `base_addr` and `stride` are the values present in the cycle `start` is accepted; later changes to those inputs have no effect on the running operation.
- R3: `mem_req_bank` equals address bits [3 +: log2(NBANK)]; after a bank takes a request it takes no other for BANK_BUSY cycles (default 4); requests leave in element order, and whenever the next element's bank is free the request leaves in that cycle, the first one in the cycle after `start` is accepted.
- R4: For a load (`op_store`=0), the k-th memory response is written to register slot k with `vr_we`=1 and its data unchanged; `mem_req_we` is 0 on load requests.
- R5: `first_valid` is 1 for exactly one cycle per load, the cycle in which slot 0 is written, and never during a store.
- R6: `done` is a one-cycle pulse in the cycle after the final slot write (load) or after the final request (store); `busy` is 0 from that cycle on.
- R7: For a store (`op_store`=1), `vr_ridx` presents element i while request i is pending, and request i carries `vr_rdata` on `mem_req_wdata` with `mem_req_we`=1.
- R8: A `start` pulse while `busy` is 1 is ignored: the running operation's addresses, timing and results are unchanged.
- R9: A command with `vlen`=0 makes no request and no register write and pulses `done` in the cycle after it is accepted.
- R10: Exactly min(`vlen`, VLEN_MAX) requests are issued, and register slots at or beyond that count are not written.
- R11: A `vlen` above VLEN_MAX (64) is treated as VLEN_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when not busy |
| op_store | input | 1 | 1 = store, 0 = load |
| base_addr | input | ADDR_W | Byte address of element 0 |
| stride | input | ADDR_W | Signed element spacing, in elements |
| vlen | input | LEN_W | Element count |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle completion pulse |
| first_valid | output | 1 | Slot 0 of a load is written this cycle |
| mem_req_valid | output | 1 | Element request this cycle |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Element byte address |
| mem_req_bank | output | BANK_W | Target bank |
| mem_req_wdata | output | DATA_W | Store data |
| mem_rsp_valid | input | 1 | Load response present |
| mem_rsp_data | input | DATA_W | Load response data |
| vr_we | output | 1 | Register slot write enable |
| vr_widx | output | IDX_W | Slot being written |
| vr_wdata | output | DATA_W | Slot write data |
| vr_ridx | output | IDX_W | Slot being read for a store |
| vr_rdata | input | DATA_W | Slot read data |

## Verification
Every result has a fixed due cycle: request i is due in the cycle a bench-side bank model predicts (the cycle after acceptance for the first free bank, later by the bank's remaining busy time), `first_valid` and slot 0 are due the memory latency after request 0, and `done` one cycle after the last slot write or the last store request. The bench numbers cycles from reset, records each output event with its cycle number at the falling edge, and compares those numbers with the predicted ones rather than waiting loosely. Register contents are read only after `done`, and the untouched slots are checked against a preloaded marker.

// File: rtl/strided_vec_agu.sv
module strided_vec_agu #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int VLEN_MAX  = 64,
  parameter int NBANK     = 4,
  parameter int BANK_BUSY = 4,
  localparam int IDX_W  = $clog2(VLEN_MAX),
  localparam int LEN_W  = $clog2(VLEN_MAX + 1),
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_store,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vlen,
  output logic              busy,
  output logic              done,
  output logic              first_valid,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BANK_W-1:0] mem_req_bank,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              vr_we,
  output logic [IDX_W-1:0]  vr_widx,
  output logic [DATA_W-1:0] vr_wdata,
  output logic [IDX_W-1:0]  vr_ridx,
  input  logic [DATA_W-1:0] vr_rdata
);

  localparam int CNT_W = $clog2(BANK_BUSY) + 1;
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(VLEN_MAX);

  logic              run_q, st_q, done_q;
  logic [ADDR_W-1:0] addr_q, step_q;
  logic [LEN_W-1:0]  len_q, iss_q, rsp_q;
  logic [NBANK-1:0]  bank_free;

  wire [LEN_W-1:0]  len_in   = (vlen > LEN_CAP) ? LEN_CAP : vlen;
  wire [BANK_W-1:0] cur_bank = addr_q[3 +: BANK_W];
  wire              pending  = iss_q < len_q;
  wire              fire     = run_q && pending && bank_free[cur_bank];
  wire              wr       = run_q && !st_q && mem_rsp_valid;
  wire              last_wr  = wr && (rsp_q == len_q - LEN_W'(1));
  wire              last_st  = fire && st_q && (iss_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      st_q   <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      step_q <= '0;
      len_q  <= '0;
      iss_q  <= '0;
      rsp_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          if (len_in == '0) begin
            done_q <= 1'b1;
          end else begin
            run_q  <= 1'b1;
            st_q   <= op_store;
            addr_q <= base_addr;
            step_q <= stride << 3;
            len_q  <= len_in;
            iss_q  <= '0;
            rsp_q  <= '0;
          end
        end
      end else begin
        if (fire) begin
          addr_q <= addr_q + step_q;
          iss_q  <= iss_q + LEN_W'(1);
        end
        if (wr) rsp_q <= rsp_q + LEN_W'(1);
        if (last_wr || last_st) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                            cnt <= '0;
      else if (fire && cur_bank == BANK_W'(b)) cnt <= CNT_W'(BANK_BUSY - 1);
      else if (cnt != '0)                    cnt <= cnt - CNT_W'(1);
    end
    assign bank_free[b] = (cnt == '0);
  end

  assign busy          = run_q;
  assign done          = done_q;
  assign first_valid   = wr && (rsp_q == '0);
  assign mem_req_valid = fire;
  assign mem_req_we    = st_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_bank  = cur_bank;
  assign mem_req_wdata = st_q ? vr_rdata : '0;
  assign vr_we         = wr;
  assign vr_widx       = rsp_q[IDX_W-1:0];
  assign vr_wdata      = mem_rsp_data;
  assign vr_ridx       = iss_q[IDX_W-1:0];

endmodule

// File: rtl/strided_vec_agu_chk.sv
module strided_vec_agu_chk #(
  parameter int NBANK     = 4,
  parameter int BANK_BUSY = 4,
  parameter int VLEN_MAX  = 64,
  localparam int IDX_W  = $clog2(VLEN_MAX),
  localparam int BANK_W = $clog2(NBANK),
  localparam int CNT_W  = $clog2(BANK_BUSY) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              first_valid,
  input logic              mem_req_valid,
  input logic [BANK_W-1:0] mem_req_bank,
  input logic              vr_we,
  input logic [IDX_W-1:0]  vr_widx
);

  logic [IDX_W-1:0] prev_widx;
  always_ff @(posedge clk) begin
    if (!rst_n)     prev_widx <= '0;
    else if (vr_we) prev_widx <= vr_widx;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_gap
    logic [CNT_W-1:0] since;
    always_ff @(posedge clk) begin
      if (!rst_n) since <= CNT_W'(BANK_BUSY - 1);
      else if (mem_req_valid && mem_req_bank == BANK_W'(b)) since <= '0;
      else if (since < CNT_W'(BANK_BUSY - 1)) since <= since + CNT_W'(1);
    end
    assert_bank_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_bank == BANK_W'(b)) |-> since == CNT_W'(BANK_BUSY - 1));
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !vr_we && !first_valid));

  assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_we && vr_widx != '0) |-> vr_widx == prev_widx + IDX_W'(1));

  assert_first_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid |-> (vr_we && vr_widx == '0));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind strided_vec_agu strided_vec_agu_chk #(
  .NBANK(NBANK), .BANK_BUSY(BANK_BUSY), .VLEN_MAX(VLEN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .first_valid(first_valid),
  .mem_req_valid(mem_req_valid), .mem_req_bank(mem_req_bank),
  .vr_we(vr_we), .vr_widx(vr_widx)
);

// File: tb/strided_vec_agu_tb.sv
module strided_vec_agu_tb;
  localparam int BUSY = 4;
  localparam int LAT  = 3;
  localparam int VMAX = 64;
  localparam logic [63:0] SENT = 64'hBAD0_BAD0_BAD0_BAD0;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        start = 0, op_store = 0;
  logic [31:0] base_addr = 0, stride = 0;
  logic [6:0]  vlen = 0;
  logic        busy, done, first_valid, mem_req_valid, mem_req_we;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_bank;
  logic [63:0] mem_req_wdata, vr_wdata, vr_rdata;
  logic        mem_rsp_valid, vr_we;
  logic [63:0] mem_rsp_data;
  logic [5:0]  vr_widx, vr_ridx;

  strided_vec_agu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
    .base_addr(base_addr), .stride(stride), .vlen(vlen),
    .busy(busy), .done(done), .first_valid(first_valid),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_bank(mem_req_bank),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .vr_we(vr_we), .vr_widx(vr_widx),
    .vr_wdata(vr_wdata), .vr_ridx(vr_ridx), .vr_rdata(vr_rdata)
  );

  function automatic logic [63:0] mdata(input logic [31:0] a);
    return {~a, a};
  endfunction
  function automatic logic [63:0] pat(input int i);
    return {32'hC0DE0000 + 32'(i), 32'h5EED0000 ^ 32'(i)};
  endfunction

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // fixed-latency banked memory model, in-order responses
  logic        pv [LAT];
  logic [63:0] pd [LAT];
  always @(posedge clk) begin
    pv[0] <= mem_req_valid && !mem_req_we;
    pd[0] <= mdata(mem_req_addr);
    for (int k = 1; k < LAT; k++) begin
      pv[k] <= pv[k-1];
      pd[k] <= pd[k-1];
    end
  end
  assign mem_rsp_valid = rst_n && pv[LAT-1];
  assign mem_rsp_data  = pd[LAT-1];

  // vector register model
  logic [63:0] vreg [VMAX];
  logic pl_en = 0, pl_store = 0;
  always @(posedge clk) begin
    if (pl_en) begin
      for (int i = 0; i < VMAX; i++) vreg[i] <= pl_store ? pat(i) : SENT;
    end else if (vr_we) begin
      vreg[vr_widx] <= vr_wdata;
    end
  end
  assign vr_rdata = vreg[vr_ridx];

  // output monitor
  int          act_cnt, first_cnt, done_cnt, first_cyc, done_cyc;
  logic [31:0] act_addr [VMAX];
  logic [1:0]  act_bank [VMAX];
  int          act_cyc  [VMAX];
  logic [63:0] act_wd   [VMAX];
  logic        act_we   [VMAX];
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid) begin
        if (act_cnt < VMAX) begin
          act_addr[act_cnt] = mem_req_addr;
          act_bank[act_cnt] = mem_req_bank;
          act_cyc[act_cnt]  = cyc;
          act_wd[act_cnt]   = mem_req_wdata;
          act_we[act_cnt]   = mem_req_we;
        end
        act_cnt++;
      end
      if (first_valid) begin first_cnt++; first_cyc = cyc; end
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int          bfree [4];
  logic [31:0] ea [VMAX];
  int          ec [VMAX];

  task automatic do_op(input bit st, input logic [31:0] base, input logic [31:0] strd,
                       input int vl, input int ghost_at);
    int n, s, t, c, b, e, k;
    n = (vl > VMAX) ? VMAX : vl;
    @(negedge clk); pl_en = 1; pl_store = st;
    @(negedge clk); pl_en = 0;
    @(negedge clk);
    act_cnt = 0; first_cnt = 0; done_cnt = 0; first_cyc = -1; done_cyc = -1;
    op_store = st; base_addr = base; stride = strd; vlen = 7'(vl); start = 1;
    s = cyc;
    t = s + 1;
    for (int i = 0; i < n; i++) begin
      ea[i] = base + 32'(i) * strd * 32'd8;
      b = int'(ea[i][4:3]);
      c = (t > bfree[b]) ? t : bfree[b];
      ec[i] = c; bfree[b] = c + BUSY; t = c + 1;
    end
    @(negedge clk);
    start = 0; base_addr = 32'hDEAD_0000; stride = 32'd5; op_store = ~st; vlen = 7'd9;
    k = 1;
    while (done_cnt == 0 && k < 3000) begin
      if (k == ghost_at) start = 1;
      @(negedge clk);
      start = 0;
      k++;
    end
    if (done_cnt == 0) chk(0, "R6", "watchdog: no done", 0, 1);
    repeat (3) @(negedge clk);

    chk(act_cnt == n, "R10", "request count", 64'(act_cnt), 64'(n));
    e = -1; for (int i = 0; i < n && i < act_cnt; i++) if (e < 0 && act_addr[i] != ea[i]) e = i;
    chk(e < 0, "R2", "element address", e < 0 ? 0 : 64'(act_addr[e]), e < 0 ? 0 : 64'(ea[e]));
    e = -1; for (int i = 0; i < n && i < act_cnt; i++) if (e < 0 && act_bank[i] != ea[i][4:3]) e = i;
    chk(e < 0, "R3", "bank select", e < 0 ? 0 : 64'(act_bank[e]), e < 0 ? 0 : 64'(ea[e][4:3]));
    e = -1; for (int i = 0; i < n && i < act_cnt; i++) if (e < 0 && act_cyc[i] != ec[i]) e = i;
    chk(e < 0, "R3", "issue cycle", e < 0 ? 0 : 64'(act_cyc[e]), e < 0 ? 0 : 64'(ec[e]));
    e = -1; for (int i = 0; i < n && i < act_cnt; i++) if (e < 0 && act_we[i] != st) e = i;
    chk(e < 0, st ? "R7" : "R4", "request write flag", e < 0 ? 0 : 64'(act_we[e]), 64'(st));
    chk(done_cnt == 1, "R6", "done pulses", 64'(done_cnt), 1);
    if (n == 0)
      chk(done_cyc == s + 1, "R9", "empty done cycle", 64'(done_cyc), 64'(s + 1));
    else if (st)
      chk(done_cyc == ec[n-1] + 1, "R6", "store done cycle", 64'(done_cyc), 64'(ec[n-1] + 1));
    else
      chk(done_cyc == ec[n-1] + LAT + 1, "R6", "load done cycle", 64'(done_cyc), 64'(ec[n-1] + LAT + 1));
    chk(busy == 0, "R6", "busy after done", 64'(busy), 0);
    if (st || n == 0) begin
      chk(first_cnt == 0, "R5", "first_valid absent", 64'(first_cnt), 0);
      e = -1; for (int i = 0; i < n && i < act_cnt; i++) if (e < 0 && act_wd[i] != pat(i)) e = i;
      chk(e < 0, "R7", "store data", e < 0 ? 0 : act_wd[e], e < 0 ? 0 : pat(e));
    end else begin
      chk(first_cnt == 1 && first_cyc == ec[0] + LAT, "R5", "first_valid cycle",
          64'(first_cyc), 64'(ec[0] + LAT));
      e = -1; for (int i = 0; i < n; i++) if (e < 0 && vreg[i] != mdata(ea[i])) e = i;
      chk(e < 0, "R4", "slot data", e < 0 ? 0 : vreg[e], e < 0 ? 0 : mdata(ea[e]));
      e = -1; for (int i = n; i < VMAX; i++) if (e < 0 && vreg[i] != SENT) e = i;
      chk(e < 0, "R10", "slots beyond length", e < 0 ? 0 : vreg[e], SENT);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !first_valid && !mem_req_valid && !vr_we, "R1", "outputs in reset",
        {busy, done, first_valid, mem_req_valid, vr_we}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !first_valid && !mem_req_valid && !vr_we, "R1", "outputs idle",
        {busy, done, first_valid, mem_req_valid, vr_we}, 0);
  endtask

  task automatic t_unit_load;      do_op(0, 32'h0000_1000, 32'd1, 64, 0);           endtask
  task automatic t_same_bank_load; do_op(0, 32'h0000_2008, 32'd4, 8, 0);            endtask
  task automatic t_odd_stride;     do_op(0, 32'h0000_3000, 32'd3, 20, 0);           endtask
  task automatic t_neg_wrap;       do_op(0, 32'h0000_0010, 32'hFFFF_FFFF, 6, 0);    endtask
  task automatic t_zero_stride;    do_op(0, 32'h0000_4018, 32'd0, 5, 0);            endtask
  task automatic t_store_stride2;  do_op(1, 32'h0000_5000, 32'd2, 16, 0);           endtask
  task automatic t_empty;          do_op(0, 32'h0000_6000, 32'd1, 0, 0);            endtask
  task automatic t_clamp_R11;      do_op(1, 32'h0000_7000, 32'd1, 100, 0);          endtask
  task automatic t_busy_start_R8;  do_op(0, 32'h0000_8000, 32'd4, 10, 3);           endtask
  task automatic t_single;         do_op(0, 32'h0000_9000, 32'd7, 1, 0);            endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 global watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) bfree[b] = 0;
    act_cnt = 0; first_cnt = 0; done_cnt = 0;
    t_reset;
    t_unit_load;
    t_same_bank_load;
    t_odd_stride;
    t_neg_wrap;
    t_zero_stride;
    t_store_stride2;
    t_empty;
    t_clamp_R11;
    t_busy_start_R8;
    t_single;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule